// File: doc/BRIEF.md
# Threshold-Triggered Four-Channel Trace Recorder

This block sits behind an acquisition front end that delivers four 16-bit raw samples together on each input beat. It also receives a shaped (filtered) version of two of those channels. When the shaped value of either monitored channel rises above a programmable signed threshold, the block records a fixed-length trace from all four raw channels. The record starts well before the trigger: every raw channel runs through its own delay line, which behaves as if it were filled with zeros at reset. A trigger near start-up therefore yields leading zeros in place of samples that never existed.

The record leaves on four per-channel valid/ready streams that move in lockstep. They share a single output slot. Each channel's valid drops on its own handshake. The next input beat is accepted only when every channel that still holds a sample is taking it in the same cycle. Back-pressure from any output therefore stalls the input stream through `in_ready`. Once the slot is loaded, the data and last flag stay stable while valid is high. Each trigger also raises a one-cycle status pulse that carries the source channels and a running trigger count.

The pre-trigger length and the record length are parameters counted in samples. For a real acquisition they are set to thousands of samples. The defaults are kept small.

Top module: `trace_capture`

## Requirements
- R1: After reset, every output valid, every last flag and `stat_valid` are 0, and `in_ready` is 1.
- R2: A trigger occurs on an accepted input beat (`in_valid` and `in_ready` both 1) while no record is in progress, when at least one monitored shaped value has gone from at most `threshold` on its previous accepted beat to strictly above it on this beat. The first beat after reset counts as coming from below. A value that stays above the threshold, or that equals it, does not trigger.
- R3: A record holds exactly REC_LEN samples per channel. Sample k of channel c is the raw channel-c value of the accepted beat numbered (T − PRE_LEN + k), where T is the number of the trigger beat and beats are numbered from 0 after reset. If that number is negative, the sample is 0.
- R4: `out_last[c]` is 1 on sample REC_LEN−1 of each record and 0 on every other sample.
- R5: A trigger from either monitored channel records all four channels, and their valids rise in the same cycle.
- R6: Threshold crossings on beats that belong to a record in progress cause no trigger, no status pulse and no extension of the record.
- R7: In the cycle after the trigger beat's clock edge, `stat_valid` is 1 for exactly one cycle. `stat_src` then carries bit 0 = channel 0 crossed and bit 1 = channel 1 crossed (3 when both cross). `stat_count` is the number of triggers since reset, starting at 1.
- R8: Output channel c hands off a sample only when `out_valid[c]` and `out_ready[c]` are both 1. While valid is held without ready, data and last are stable. `in_ready` is 0 whenever some channel holds valid without ready.
- R9: No output channel presents valid outside a record.
- R10: The threshold comparison is signed two's complement. For example, with a threshold of −100, a shaped value of 5 is above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat accepted this cycle when high with in_valid |
| in_data | input | NCH*SAMPLE_W | Raw samples, channel c in bits [c*SAMPLE_W +: SAMPLE_W] |
| shaped0 | input | SAMPLE_W | Signed shaped value of channel 0, qualified by the input beat |
| shaped1 | input | SAMPLE_W | Signed shaped value of channel 1, qualified by the input beat |
| threshold | input | SAMPLE_W | Signed trigger level |
| out_valid | output | NCH | Per-channel output valid |
| out_ready | input | NCH | Per-channel output ready |
| out_last | output | NCH | Per-channel final sample of a record |
| out_data | output | NCH*SAMPLE_W | Per-channel output sample, same slicing as in_data |
| stat_valid | output | 1 | One-cycle status pulse per trigger |
| stat_src | output | 2 | Channels that crossed on the trigger beat |
| stat_count | output | CNT_W | Triggers since reset, wrapping |

## Verification
Two situations are hard to reach from the ports. The first is a record that overlaps the zero-filled start of the delay lines while one output channel is stalling. The second is a second crossing that lands inside a record already in progress. The bench triggers within the first PRE_LEN beats after reset, so the leading samples must come out as zeros. In a later record it holds individual output readies low on a repeating cycle pattern, so the input stalls midway through the record. Crossings on the other channel during the record, an exact-equality level and a positive value under a negative threshold cover the trigger corners.

// File: rtl/trace_capture_pkg.sv
package trace_capture_pkg;
  // Bit 0: channel 0 crossed, bit 1: channel 1 crossed.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CH0  = 2'd1,
    SRC_CH1  = 2'd2,
    SRC_BOTH = 2'd3
  } trig_src_e;

  localparam int MON_CH = 2;  // number of shaped channels watched
endpackage

// File: rtl/edge_trig.sv
module edge_trig #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic signed [W-1:0] value,
  input  logic signed [W-1:0] thr,
  output logic                rise
);
  logic above, above_q;

  assign above = value > thr;
  assign rise  = step & above & ~above_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    above_q <= 1'b0;
    else if (step) above_q <= above;
  end
endmodule

// File: rtl/delay_line.sv
module delay_line #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] ptr;
  logic          primed;  // every slot has been written at least once

  assign dout = primed ? mem[ptr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      primed <= 1'b0;
    end else if (shift) begin
      if (ptr == AW'(DEPTH - 1)) begin
        ptr    <= '0;
        primed <= 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (shift) mem[ptr] <= din;
  end
endmodule

// File: rtl/capture_seq.sv
module capture_seq #(
  parameter int REC_LEN = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic take,
  output logic busy,
  output logic at_end
);
  localparam int IW = (REC_LEN > 1) ? $clog2(REC_LEN) : 1;

  logic [IW-1:0] idx;

  assign at_end = idx == IW'(REC_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (take) begin
      if (at_end) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        busy <= busy | start;
        idx  <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_capture_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int NCH      = 4,
  parameter int PRE_LEN  = 16,
  parameter int REC_LEN  = 24,
  parameter int CNT_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [NCH*SAMPLE_W-1:0]    in_data,
  input  logic signed [SAMPLE_W-1:0] shaped0,
  input  logic signed [SAMPLE_W-1:0] shaped1,
  input  logic signed [SAMPLE_W-1:0] threshold,
  output logic [NCH-1:0]             out_valid,
  input  logic [NCH-1:0]             out_ready,
  output logic [NCH-1:0]             out_last,
  output logic [NCH*SAMPLE_W-1:0]    out_data,
  output logic                       stat_valid,
  output logic [1:0]                 stat_src,
  output logic [CNT_W-1:0]           stat_count
);
  logic signed [SAMPLE_W-1:0] mon [MON_CH];
  logic [MON_CH-1:0]          rise;
  logic [NCH*SAMPLE_W-1:0]    delayed;
  logic [NCH-1:0]             pend;
  logic free, beat, busy, trig, take, at_end;
  trig_src_e src;

  assign mon[0] = shaped0;
  assign mon[1] = shaped1;

  // Slot is free when every pending channel is emptied this cycle.
  assign free     = &(~pend | out_ready);
  assign in_ready = free;
  assign beat     = in_valid & free;
  assign trig     = beat & ~busy & (|rise);
  assign take     = beat & (busy | trig);
  assign src      = trig_src_e'(rise);

  for (genvar g = 0; g < MON_CH; g++) begin : g_mon
    edge_trig #(.W(SAMPLE_W)) u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (beat),
      .value (mon[g]),
      .thr   (threshold),
      .rise  (rise[g])
    );
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    delay_line #(.W(SAMPLE_W), .DEPTH(PRE_LEN)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (beat),
      .din   (in_data[g*SAMPLE_W +: SAMPLE_W]),
      .dout  (delayed[g*SAMPLE_W +: SAMPLE_W])
    );
  end

  capture_seq #(.REC_LEN(REC_LEN)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (trig),
    .take   (take),
    .busy   (busy),
    .at_end (at_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      out_last <= '0;
      out_data <= '0;
    end else if (take) begin
      pend     <= '1;
      out_last <= {NCH{at_end}};
      out_data <= delayed;
    end else begin
      pend <= pend & ~out_ready;
    end
  end

  assign out_valid = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      stat_src   <= SRC_NONE;
      stat_count <= '0;
    end else begin
      stat_valid <= trig;
      if (trig) begin
        stat_src   <= src;
        stat_count <= stat_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
  parameter int SAMPLE_W = 16,
  parameter int NCH      = 4,
  parameter int CNT_W    = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic [NCH-1:0]          out_valid,
  input logic [NCH-1:0]          out_ready,
  input logic [NCH-1:0]          out_last,
  input logic [NCH*SAMPLE_W-1:0] out_data,
  input logic                    stat_valid,
  input logic [1:0]              stat_src,
  input logic [CNT_W-1:0]        stat_count
);
  for (genvar g = 0; g < NCH; g++) begin : g_hold
    p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[g] && !out_ready[g]) |=> (out_valid[g] &&
        $stable(out_data[g*SAMPLE_W +: SAMPLE_W]) && $stable(out_last[g])));
  end

  p_stall_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & ~out_ready)) |-> !in_ready);

  p_lockstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid != '0) && ($past(out_valid) == '0)) |-> (&out_valid));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_count == $past(stat_count) + 1'b1));

  p_src_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_src != 2'b00));
endmodule

bind trace_capture trace_capture_chk #(
  .SAMPLE_W (SAMPLE_W),
  .NCH      (NCH),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_last   (out_last),
  .out_data   (out_data),
  .stat_valid (stat_valid),
  .stat_src   (stat_src),
  .stat_count (stat_count)
);

// File: tb/sim_trace_capture.sv
module sim_trace_capture;
  localparam int W   = 16;
  localparam int NCH = 4;
  localparam int PRE = 16;
  localparam int REC = 24;
  localparam int CW  = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic                rst_n;
  logic                in_valid;
  logic                in_ready;
  logic [NCH*W-1:0]    in_data;
  logic signed [W-1:0] shaped0, shaped1, threshold;
  logic [NCH-1:0]      out_valid, out_ready, out_last;
  logic [NCH*W-1:0]    out_data;
  logic                stat_valid;
  logic [1:0]          stat_src;
  logic [CW-1:0]       stat_count;

  trace_capture u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .shaped0(shaped0), .shaped1(shaped1),
    .threshold(threshold), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .out_data(out_data), .stat_valid(stat_valid),
    .stat_src(stat_src), .stat_count(stat_count)
  );

  int n_tests = 0, n_fail = 0;
  int bn = 0;                 // index of the next beat to be accepted
  int exp_trig = 0, exp_rec = 0, exp_cnt = 0, stat_seen = 0, stall_seen = 0;
  logic [1:0] exp_src = 2'b00;
  int rec_idx [NCH];
  int rec_done [NCH];
  logic [W-1:0] prev_d [NCH];
  logic prev_hold [NCH];
  bit bp_en = 0;
  int cyc = 0;

  function automatic logic [W-1:0] smp(int b, int ch);
    if (b < 0) return '0;
    return W'(b * 4 + ch + 1);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Output monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int ch = 0; ch < NCH; ch++) begin
        logic [W-1:0] d;
        d = out_data[ch*W +: W];
        if (prev_hold[ch])
          chk(out_valid[ch] && d == prev_d[ch], "R8", "held data", d, prev_d[ch]);
        prev_hold[ch] = out_valid[ch] && !out_ready[ch];
        prev_d[ch]    = d;
        if (out_valid[ch] && out_ready[ch]) begin
          if (rec_done[ch] >= exp_rec) begin
            chk(0, "R9", "beat outside record on channel", ch, -1);
          end else begin
            chk(d == smp(exp_trig - PRE + rec_idx[ch], ch), "R3", "sample",
                d, smp(exp_trig - PRE + rec_idx[ch], ch));
            chk(out_last[ch] == (rec_idx[ch] == REC - 1), "R4", "last flag",
                out_last[ch], rec_idx[ch] == REC - 1);
            if (rec_idx[ch] == REC - 1) begin
              rec_idx[ch] = 0;
              rec_done[ch]++;
            end else begin
              rec_idx[ch]++;
            end
          end
        end
      end
      if (out_valid != '0)
        chk(in_ready == &(~out_valid | out_ready), "R8", "in_ready", in_ready,
            &(~out_valid | out_ready));
      if (!in_ready) stall_seen++;
      if (stat_valid) begin
        stat_seen++;
        chk(stat_src == exp_src, "R7", "stat_src", stat_src, exp_src);
        chk(stat_count == CW'(exp_cnt), "R7", "stat_count", stat_count, exp_cnt);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    if (bp_en) begin
      out_ready[0] = (cyc % 5) != 1;
      out_ready[2] = (cyc % 3) != 0;
      out_ready[1] = 1'b1;
      out_ready[3] = 1'b1;
    end else begin
      out_ready = '1;
    end
  end

  // Offers one beat and holds it until it is accepted; returns at posedge+1.
  task automatic beat(input logic signed [W-1:0] s0, input logic signed [W-1:0] s1);
    bit acc;
    in_valid = 1'b1;
    shaped0  = s0;
    shaped1  = s1;
    for (int ch = 0; ch < NCH; ch++) in_data[ch*W +: W] = smp(bn, ch);
    do begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
    end while (!acc);
    bn++;
    in_valid = 1'b0;
  endtask

  task automatic beats(int n, input logic signed [W-1:0] s0, input logic signed [W-1:0] s1);
    for (int i = 0; i < n; i++) beat(s0, s1);
  endtask

  task automatic all_done(string req, int n);
    for (int ch = 0; ch < NCH; ch++)
      chk(rec_done[ch] == n, req, "records finished on channel", rec_done[ch], n);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    shaped0 = '0; shaped1 = '0; threshold = 16'sd1000;
    for (int ch = 0; ch < NCH; ch++) begin
      rec_idx[ch] = 0; rec_done[ch] = 0; prev_hold[ch] = 0; prev_d[ch] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid", out_valid, 0);
    chk(out_last == '0, "R1", "out_last", out_last, 0);
    chk(stat_valid == 1'b0, "R1", "stat_valid", stat_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    @(posedge clk);
    #1;
  endtask

  // Trigger inside the zero-filled window; crossings during record ignored.
  task automatic t_first_record;
    beats(3, 16'sd0, 16'sd0);
    exp_trig = bn; exp_rec = 1; exp_src = 2'b01; exp_cnt = 1;
    beat(16'sd2000, 16'sd0);
    chk(stat_valid == 1'b1, "R7", "pulse after trigger beat", stat_valid, 1);
    beats(4, 16'sd2000, 16'sd0);
    beat(16'sd2000, 16'sd1500);  // R6: channel 1 crosses mid-record
    beats(2, 16'sd2000, 16'sd0);
    beat(16'sd2000, 16'sd1500);  // R6: second crossing, still in record
    beats(REC + 2, 16'sd2000, 16'sd0);
    repeat (3) @(posedge clk);
    #1;
    all_done("R5", 1);
    chk(stat_seen == 1, "R6", "status pulses", stat_seen, 1);
    beats(4, 16'sd2000, 16'sd0);  // R2: level stays high, no retrigger
    chk(stat_seen == 1, "R2", "held level", stat_seen, 1);
  endtask

  // Equal to threshold is not above it.
  task automatic t_equal_level;
    beats(2, 16'sd0, 16'sd0);
    beats(3, 16'sd1000, 16'sd1000);
    beats(2, 16'sd999, 16'sd0);
    repeat (2) @(posedge clk);
    #1;
    chk(stat_seen == 1, "R2", "equal level triggered", stat_seen, 1);
    all_done("R9", 1);
  endtask

  // Signed compare, plus output back-pressure through the record.
  task automatic t_signed_backpressure;
    threshold = -16'sd100;
    beats(2, -16'sd300, -16'sd200);
    bp_en = 1;
    stall_seen = 0;
    exp_trig = bn; exp_rec = 2; exp_src = 2'b10; exp_cnt = 2;
    beat(-16'sd300, 16'sd5);   // R10: 5 > -100 only when signed
    beats(REC + 2, -16'sd300, 16'sd5);
    repeat (6) @(posedge clk);
    #1;
    bp_en = 0;
    repeat (3) @(posedge clk);
    #1;
    all_done("R10", 2);
    chk(stat_seen == 2, "R10", "status pulses", stat_seen, 2);
    chk(stall_seen > 0, "R8", "input stalled", stall_seen, 1);
  endtask

  // Both channels cross on the same beat.
  task automatic t_both;
    threshold = 16'sd0;
    beats(2, -16'sd1, -16'sd1);
    exp_trig = bn; exp_rec = 3; exp_src = 2'b11; exp_cnt = 3;
    beat(16'sd7, 16'sd9);
    beats(REC + 1, 16'sd7, 16'sd9);
    repeat (3) @(posedge clk);
    #1;
    all_done("R5", 3);
    chk(stat_seen == 3, "R7", "status pulses", stat_seen, 3);
  endtask

  initial begin
    out_ready = '1;
    t_reset();
    t_first_record();
    t_equal_level();
    t_signed_backpressure();
    t_both();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule